// File: doc/BRIEF.md
# Multi-mode serial bit-rate generator

This block derives the timing of one serial channel from the system clock. A power-of-four prescaler feeds an (N+1) divider. Together they produce a basic-clock tick. A per-bit counter then groups a mode-dependent number of basic clocks into one bit period.

Three modes are available:
- **Asynchronous:** 16 basic clocks per bit.
- **Clock synchronous:** 2 basic clocks per bit, with a square-wave serial clock.
- **Smart card:** 32, 64, 372 or 256 basic clocks per bit.

A small CPU-side register port sets the divisor and the control fields and reads them back. Every write restarts the whole chain, so the new rate takes effect cleanly from the write cycle.

Top module: `sci_bitrate_gen`

## Requirements
- R1: After reset the divisor reads 0xFF and the control register reads 0x00. `base_tick` and `bit_tick` are low and `sclk` is high.
- R2: A write with `wr_addr`=0 loads the divisor. A write with `wr_addr`=1 loads the control register from `wr_data[5:0]`, and bits 7:6 read back as 0. The control fields are: `[1:0]` prescaler select n, `[3:2]` mode (00 async, 01 sync, 10 smart card, 11 treated as async), and `[5:4]` smart-card select. `rd_data` shows the register chosen by `rd_addr` in the same cycle.
- R3: `base_tick` is a one-cycle pulse repeating every 2 × 4^n × (N+1) system clocks.
- R4: In asynchronous mode, `bit_tick` pulses once per 16 basic-clock periods.
- R5: In synchronous mode, a bit lasts 2 basic-clock periods. `sclk` toggles on each `base_tick`: it goes low on the first tick after a restart and high on each `bit_tick`. In all other modes `sclk` stays high.
- R6: In smart card mode, the select values 00, 01, 10 and 11 give 32, 64, 372 and 256 basic clocks per bit.
- R7: Any write restarts the chain. No tick occurs in the cycle after the write. The first `base_tick` comes exactly one basic period after the write edge, and the first `bit_tick` comes exactly one bit period after it.
- R8: `bit_tick` is only ever high together with `base_tick`.
- R9: Mode code 11 behaves exactly as asynchronous mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 divisor, 1 control |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read select: 0 divisor, 1 control |
| rd_data | output | 8 | Read data |
| base_tick | output | 1 | Basic-clock pulse |
| bit_tick | output | 1 | Bit-period pulse |
| sclk | output | 1 | Synchronous serial clock |

## Verification
The bench builds the block with its default 8-bit divisor, so both extremes of the divisor are in reach: N=0, giving the shortest basic period of 2 clocks, and N=255. Prescaler selects 0 to 3 reach a basic period of 2048 clocks. Within the run budget, the longest bit checked is 8192 clocks, and this includes the 372-cycle smart-card setting. A restart issued partway through a period confirms that timing is measured from the last write.

// File: rtl/brg_pkg.sv
package brg_pkg;

  typedef enum logic [1:0] {
    MODE_ASYNC = 2'b00,
    MODE_SYNC  = 2'b01,
    MODE_CARD  = 2'b10,
    MODE_RSVD  = 2'b11
  } brg_mode_e;

  localparam int unsigned BITCNT_W = 9;
  localparam int unsigned CTRL_W   = 6;

  function automatic logic [BITCNT_W-1:0] card_cycles(input logic [1:0] sel);
    logic [BITCNT_W-1:0] r;
    case (sel)
      2'b00:   r = BITCNT_W'(32);
      2'b01:   r = BITCNT_W'(64);
      2'b10:   r = BITCNT_W'(372);
      default: r = BITCNT_W'(256);
    endcase
    return r;
  endfunction

  function automatic logic [BITCNT_W-1:0] basics_per_bit(input brg_mode_e mode,
                                                         input logic [1:0] sel);
    logic [BITCNT_W-1:0] r;
    case (mode)
      MODE_SYNC: r = BITCNT_W'(2);
      MODE_CARD: r = card_cycles(sel);
      default:   r = BITCNT_W'(16);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/brg_prescaler.sv
module brg_prescaler #(
  parameter int unsigned SEL_W = 2,
  localparam int unsigned CNT_W = 2 * ((1 << SEL_W) - 1) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic             cnt_en;

  always_comb begin
    limit  = (CNT_W'(1) << (2 * sel + 1)) - CNT_W'(1);
    tick   = (cnt_q == limit);
    cnt_en = 1'b1;
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/brg_divider.sv
module brg_divider #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  logic [DIV_W-1:0] limit,
  output logic             wrap
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    wrap   = step && (cnt_q == limit);
    cnt_en = restart || step;
    if (restart || wrap) cnt_d = '0;
    else                 cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/brg_bitcount.sv
module brg_bitcount #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    done   = step && (cnt_q == limit);
    cnt_en = restart || step;
    if (restart || done) cnt_d = '0;
    else                 cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sci_bitrate_gen.sv
module sci_bitrate_gen
  import brg_pkg::*;
#(
  parameter int unsigned DIV_W   = 8,
  parameter logic [7:0]  DIV_RST = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [DIV_W-1:0] wr_data,
  input  logic             rd_addr,
  output logic [DIV_W-1:0] rd_data,
  output logic             base_tick,
  output logic             bit_tick,
  output logic             sclk
);

  localparam int unsigned SEL_W = 2;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // register file
  logic [DIV_W-1:0]  div_q, div_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              div_en, ctrl_en, restart;

  always_comb begin
    div_en  = wr_en && !wr_addr;
    ctrl_en = wr_en &&  wr_addr;
    restart = wr_en;
    div_d   = wr_data;
    ctrl_d  = wr_data[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      div_q  <= DIV_W'(DIV_RST);
      ctrl_q <= '0;
    end else begin
      if (div_en)  div_q  <= div_d;
      if (ctrl_en) ctrl_q <= ctrl_d;
    end
  end

  assign rd_data = rd_addr ? DIV_W'(ctrl_q) : div_q;

  // field decode
  logic [SEL_W-1:0]    psel;
  brg_mode_e           mode;
  logic [1:0]          card_sel;
  logic [BITCNT_W-1:0] bit_limit;

  always_comb begin
    psel      = ctrl_q[1:0];
    mode      = brg_mode_e'(ctrl_q[3:2]);
    card_sel  = ctrl_q[5:4];
    bit_limit = basics_per_bit(mode, card_sel) - BITCNT_W'(1);
  end

  // timing chain
  logic presc_tick, basic_wrap, bit_done;

  brg_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .restart (restart),
    .sel     (psel),
    .tick    (presc_tick)
  );

  brg_divider #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .restart (restart),
    .step    (presc_tick),
    .limit   (div_q),
    .wrap    (basic_wrap)
  );

  brg_bitcount #(.CNT_W(BITCNT_W)) u_bits (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .restart (restart),
    .step    (basic_wrap),
    .limit   (bit_limit),
    .done    (bit_done)
  );

  // registered outputs
  logic base_q, base_d, bit_q, bit_d, sclk_q, sclk_d;

  always_comb begin
    base_d = basic_wrap;
    bit_d  = bit_done;
    sclk_d = sclk_q;
    if (restart) begin
      base_d = 1'b0;
      bit_d  = 1'b0;
      sclk_d = 1'b1;
    end else if (mode != MODE_SYNC) begin
      sclk_d = 1'b1;
    end else if (basic_wrap) begin
      sclk_d = ~sclk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      base_q <= 1'b0;
      bit_q  <= 1'b0;
      sclk_q <= 1'b1;
    end else begin
      base_q <= base_d;
      bit_q  <= bit_d;
      sclk_q <= sclk_d;
    end
  end

  assign base_tick = base_q;
  assign bit_tick  = bit_q;
  assign sclk      = sclk_q;

endmodule

// File: rtl/sci_bitrate_gen_chk.sv
module sci_bitrate_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       base_tick,
  input logic       bit_tick,
  input logic       sclk,
  input logic [1:0] mode
);

  AST_BIT_WITH_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> base_tick); // R8

  AST_BASE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    base_tick |=> !base_tick); // R3

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (!base_tick && !bit_tick)); // R7

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b01) |-> sclk); // R5

  AST_SCLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (base_tick && mode == 2'b01) |-> !$stable(sclk)); // R5

  AST_SCLK_HIGH_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> sclk); // R5

endmodule

bind sci_bitrate_gen sci_bitrate_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .base_tick (base_tick),
  .bit_tick  (bit_tick),
  .sclk      (sclk),
  .mode      (ctrl_q[3:2])
);

// File: tb/sci_bitrate_gen_bench.sv
module sci_bitrate_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_addr = 1'b0;
  logic [7:0] rd_data;
  logic       base_tick, bit_tick, sclk;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk; // 50 MHz

  sci_bitrate_gen u_sci_bitrate_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .base_tick(base_tick), .bit_tick(bit_tick), .sclk(sclk)
  );

  // {divisor, control, basic period, bit period} in system clocks
  localparam int NVEC = 11;
  localparam logic [79:0] VEC [NVEC] = '{
    {8'd0,   8'h00, 32'd2,    32'd32},    // async, shortest
    {8'd0,   8'h04, 32'd2,    32'd4},     // sync, shortest
    {8'd3,   8'h01, 32'd32,   32'd512},   // async n=1
    {8'd255, 8'h00, 32'd512,  32'd8192},  // async, N=255
    {8'd0,   8'h07, 32'd128,  32'd256},   // sync n=3
    {8'd1,   8'h28, 32'd4,    32'd1488},  // card S=372
    {8'd0,   8'h09, 32'd8,    32'd256},   // card S=32 n=1
    {8'd2,   8'h18, 32'd6,    32'd384},   // card S=64
    {8'd0,   8'h3A, 32'd32,   32'd8192},  // card S=256 n=2
    {8'd255, 8'h05, 32'd2048, 32'd4096},  // sync n=1 N=255
    {8'd0,   8'h0C, 32'd2,    32'd32}     // reserved mode = async
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write_reg(input logic addr, input logic [7:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // counts negedges after the write edge; sample c == k follows edge write+k
  task automatic measure(input int period, input int bitlen, input logic [1:0] mode,
                         input string mreq);
    int c1 = 0, c2 = 0, cb = 0;
    int s1 = -1, sb = -1, bb = -1;
    for (int c = 1; c <= 20000; c++) begin
      @(negedge clk);
      if (base_tick) begin
        if (c1 == 0) begin c1 = c; s1 = sclk; end
        else if (c2 == 0) c2 = c;
      end
      if (bit_tick && cb == 0) begin cb = c; sb = sclk; bb = base_tick; end
      if (cb != 0 && c2 != 0) break;
    end
    check("R7", "first base tick after write", c1, period);
    check("R3", "base tick spacing", c2 - c1, period);
    check(mreq, "first bit tick after write", cb, period * bitlen / period * 1);
    check("R8", "base high with bit tick", bb, 1);
    check("R5", "sclk at first base tick", s1, (mode == 2'b01) ? 0 : 1);
    check("R5", "sclk at bit tick", sb, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd_addr = 1'b0; #1;
    check("R1", "divisor reset", rd_data, 8'hFF);
    rd_addr = 1'b1; #1;
    check("R1", "control reset", rd_data, 8'h00);
    check("R1", "base_tick reset", base_tick, 0);
    check("R1", "bit_tick reset", bit_tick, 0);
    check("R1", "sclk reset", sclk, 1);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] nv, cv;
      int per, bits;
      string mreq;
      nv = VEC[i][79:72]; cv = VEC[i][71:64];
      per = int'(VEC[i][63:32]); bits = int'(VEC[i][31:0]);
      case (cv[3:2])
        2'b01:   mreq = "R5";
        2'b10:   mreq = "R6";
        2'b11:   mreq = "R9";
        default: mreq = "R4";
      endcase
      write_reg(1'b0, nv);
      write_reg(1'b1, cv);
      measure(per, bits, cv[3:2], mreq);
    end

    // R2 readback, unused control bits
    write_reg(1'b1, 8'hFF);
    rd_addr = 1'b1; #1;
    check("R2", "control readback masks bits 7:6", rd_data, 8'h3F);
    write_reg(1'b0, 8'h5A);
    rd_addr = 1'b0; #1;
    check("R2", "divisor readback", rd_data, 8'h5A);

    // R7 restart partway through a period: N=0 n=1 async -> period 8, bit 128
    write_reg(1'b0, 8'h00);
    write_reg(1'b1, 8'h01);
    repeat (5) @(negedge clk);
    check("R7", "no tick before restart", base_tick, 0);
    write_reg(1'b0, 8'h00);
    measure(8, 128, 2'b00, "R4");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule